// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two buses, A and B, in lanes of `LANE_W` bits, with `SECTIONS` independent lanes side by side (two lanes of 8 bits by default, 16 bits in total). Each lane holds two storage registers. One stores A-bus data for sending toward B. The other stores B-bus data for sending toward A. Each register loads its input bus when its own capture strobe rises. A source-select input per direction picks live data from the opposite bus or the stored word. An active-low output enable and a direction input decide which bus, if any, this block drives.

Bidirectional pins are split into an input vector, an output vector and a per-lane drive-enable for each bus, so no tri-state cells are used. Everything runs on one system clock. A capture strobe counts as rising on a clock edge where it is sampled high and was sampled low on the previous edge. The output paths are purely combinational from the inputs and the stored words. Capture never depends on the enable or the direction. When a register's source bus is being driven by this block, the register loads the driven value.

Top module: `dual_lane_xcvr`

## Requirements
- R1: On a clock edge where `cap_ab[s]` has risen (high now, low at the previous edge), lane s stores the value on its A side into its A-to-B register.
- R2: On a clock edge where `cap_ba[s]` has risen, lane s stores the value on its B side into its B-to-A register.
- R3: A register changes only on a rising edge of its strobe or on reset. A strobe held low or held high leaves the contents unchanged, whatever the buses carry.
- R4: While `oe_n[s]` is 1, `a_oe[s]` and `b_oe[s]` are both 0, and both registers of that lane still capture.
- R5: While `oe_n[s]` is 0, `dir[s]`=1 sets `b_oe[s]`=1 and `a_oe[s]`=0, and `dir[s]`=0 sets `a_oe[s]`=1 and `b_oe[s]`=0.
- R6: While B is driven, the B output carries live A input when `sel_ab[s]`=0, and the stored A-to-B word when `sel_ab[s]`=1.
- R7: While A is driven, the A output carries live B input when `sel_ba[s]`=0, and the stored B-to-A word when `sel_ba[s]`=1.
- R8: `a_oe[s]` and `b_oe[s]` are never 1 at the same time.
- R9: When a register's source bus is driven by the block, a capture stores the driven output value, not the external input on that bus.
- R10: A synchronous active-low `rst_n` clears every register to zero.
- R11: Lanes are independent. The controls and strobes of one lane have no effect on another lane's outputs or stored words. Lane s uses data bits [s*LANE_W +: LANE_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| oe_n | input | SECTIONS | Per-lane output enable, active low |
| dir | input | SECTIONS | Per-lane direction: 1 drives B, 0 drives A |
| sel_ab | input | SECTIONS | B output source: 0 live A, 1 stored word |
| sel_ba | input | SECTIONS | A output source: 0 live B, 1 stored word |
| cap_ab | input | SECTIONS | Capture strobe of the A-to-B register |
| cap_ba | input | SECTIONS | Capture strobe of the B-to-A register |
| a_in | input | SECTIONS*LANE_W | Value seen on the A bus |
| a_out | output | SECTIONS*LANE_W | Value offered to the A bus |
| a_oe | output | SECTIONS | Per-lane drive enable for the A bus |
| b_in | input | SECTIONS*LANE_W | Value seen on the B bus |
| b_out | output | SECTIONS*LANE_W | Value offered to the B bus |
| b_oe | output | SECTIONS | Per-lane drive enable for the B bus |

## Verification
Some properties are checked on every cycle: the two buses are never driven together, isolation holds while the enable is high, a strobe rise loads the source word, no rise holds the word, and a capture on a driven bus takes the driven value. The bench's scenarios are needed for the rest. They cover the full sweep of enable, direction and both selects against stored and live data, the captures during isolation, the difference between a held-high strobe and a new rise, the values left by reset, and the absence of crosstalk between lanes.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the registered bus transceiver.
package xcvr_pkg;
    // Per-lane control bundle: enable (active low), direction, source selects.
    typedef struct packed {
        logic oe_n;
        logic dir;
        logic sel_ab;
        logic sel_ba;
    } lane_ctrl_t;
endpackage

// File: rtl/xcvr_capture_reg.sv
`timescale 1ns/1ps
// Module: xcvr_capture_reg
// Stores d on each clock edge where stb rose since the previous edge.
// Assumes stb is synchronous to clk. The strobe history register is not
// reset, so it follows stb through reset. Contents clear on synchronous reset.
module xcvr_capture_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic stb_q;

    // Remember the strobe level from the previous edge.
    always_ff @(posedge clk) begin
        stb_q <= stb;
    end

    // Load on a strobe rise; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (stb && !stb_q)
            q <= d;
    end

    AST_LOAD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb) |=> q == $past(d)); // R1
    AST_HOLD_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(stb) |=> $stable(q)); // R3
endmodule

// File: rtl/xcvr_lane.sv
`timescale 1ns/1ps
// Module: xcvr_lane
// One lane: two capture registers, the two output source muxes and the
// drive-enable decode. Assumes the in vectors show the external bus level.
// The lane substitutes its own driven value when it feeds a register.
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  lane_ctrl_t   ctrl,
    input  logic         cap_ab,
    input  logic         cap_ba,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    logic [W-1:0] st_ab;
    logic [W-1:0] st_ba;
    logic [W-1:0] a_side;
    logic [W-1:0] b_side;

    // Decode which bus, if any, is driven.
    always_comb begin
        a_oe = !ctrl.oe_n && !ctrl.dir;
        b_oe = !ctrl.oe_n &&  ctrl.dir;
    end

    // Pick live or stored data for each output.
    always_comb begin
        a_out = ctrl.sel_ba ? st_ba : b_in;
        b_out = ctrl.sel_ab ? st_ab : a_in;
    end

    // Resolve the true bus level seen by each register.
    always_comb begin
        a_side = a_oe ? a_out : a_in;
        b_side = b_oe ? b_out : b_in;
    end

    xcvr_capture_reg #(.W(W)) u_reg_ab (
        .clk(clk), .rst_n(rst_n), .stb(cap_ab), .d(a_side), .q(st_ab)
    );

    xcvr_capture_reg #(.W(W)) u_reg_ba (
        .clk(clk), .rst_n(rst_n), .stb(cap_ba), .d(b_side), .q(st_ba)
    );

    AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_oe && b_oe)); // R8
    AST_ISOLATION: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.oe_n |-> (!a_oe && !b_oe)); // R4
    AST_DRIVEN_CAPTURE_AB: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe && $rose(cap_ab)) |=> st_ab == $past(a_out)); // R9
    AST_DRIVEN_CAPTURE_BA: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && $rose(cap_ba)) |=> st_ba == $past(b_out)); // R9
endmodule

// File: rtl/dual_lane_xcvr.sv
`timescale 1ns/1ps
// Module: dual_lane_xcvr
// Top: SECTIONS independent lanes of LANE_W bits each. Lane s owns bit s
// of every control vector and data bits [s*LANE_W +: LANE_W].
module dual_lane_xcvr
    import xcvr_pkg::*;
#(
    parameter int LANE_W   = 8,
    parameter int SECTIONS = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SECTIONS-1:0]          oe_n,
    input  logic [SECTIONS-1:0]          dir,
    input  logic [SECTIONS-1:0]          sel_ab,
    input  logic [SECTIONS-1:0]          sel_ba,
    input  logic [SECTIONS-1:0]          cap_ab,
    input  logic [SECTIONS-1:0]          cap_ba,
    input  logic [SECTIONS*LANE_W-1:0]   a_in,
    output logic [SECTIONS*LANE_W-1:0]   a_out,
    output logic [SECTIONS-1:0]          a_oe,
    input  logic [SECTIONS*LANE_W-1:0]   b_in,
    output logic [SECTIONS*LANE_W-1:0]   b_out,
    output logic [SECTIONS-1:0]          b_oe
);
    localparam int TOTAL_W = SECTIONS * LANE_W;

    for (genvar s = 0; s < SECTIONS; s++) begin : g_lane
        lane_ctrl_t ctl;

        // Bundle this lane's control bits.
        always_comb begin
            ctl.oe_n   = oe_n[s];
            ctl.dir    = dir[s];
            ctl.sel_ab = sel_ab[s];
            ctl.sel_ba = sel_ba[s];
        end

        xcvr_lane #(.W(LANE_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctrl   (ctl),
            .cap_ab (cap_ab[s]),
            .cap_ba (cap_ba[s]),
            .a_in   (a_in[s*LANE_W +: LANE_W]),
            .b_in   (b_in[s*LANE_W +: LANE_W]),
            .a_out  (a_out[s*LANE_W +: LANE_W]),
            .a_oe   (a_oe[s]),
            .b_out  (b_out[s*LANE_W +: LANE_W]),
            .b_oe   (b_oe[s])
        );
    end

    AST_NO_BUS_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe & b_oe) == '0); // R8
    initial assert (TOTAL_W > 0); // R11
endmodule

// File: tb/dual_lane_xcvr_test.sv
`timescale 1ns/1ps
module dual_lane_xcvr_test;
    localparam int W = 8;
    localparam int S = 2;

    logic clk = 0;
    logic rst_n = 0;
    logic [S-1:0] oe_n = '1, dir = '0, sel_ab = '0, sel_ba = '0;
    logic [S-1:0] cap_ab = '0, cap_ba = '0;
    logic [S*W-1:0] a_in = '0, b_in = '0;
    logic [S*W-1:0] a_out, b_out;
    logic [S-1:0] a_oe, b_oe;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk; // 250 MHz

    dual_lane_xcvr #(.LANE_W(W), .SECTIONS(S)) uut (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Lane-0 strobe pulse: set at a falling edge, cleared at the next one.
    task automatic pulse0(input bit ab, input bit ba);
        @(negedge clk);
        cap_ab[0] = ab; cap_ba[0] = ba;
        @(negedge clk);
        cap_ab[0] = 0; cap_ba[0] = 0;
    endtask

    // Sweep vectors: {oe_n, dir, sel_ab, sel_ba, src}
    // src: 0 none, 1 B<=live A, 2 B<=stored AB, 3 A<=live B, 4 A<=stored BA
    localparam logic [6:0] VEC [16] = '{
        7'b0000_011, 7'b0001_100, 7'b0010_011, 7'b0011_100,
        7'b0100_001, 7'b0101_001, 7'b0110_010, 7'b0111_010,
        7'b1000_000, 7'b1001_000, 7'b1010_000, 7'b1011_000,
        7'b1100_000, 7'b1101_000, 7'b1110_000, 7'b1111_000
    };

    initial begin
        repeat (5) @(negedge clk);
        check("R4 reset a_oe", a_oe, 0);
        check("R4 reset b_oe", b_oe, 0);
        rst_n = 1;

        // R10: stored words read back as zero after reset
        @(negedge clk);
        oe_n = 2'b00; dir = 2'b11; sel_ab = 2'b11; sel_ba = 2'b11;
        #1 check("R10 stored AB zero", b_out, 0);
        @(negedge clk);
        dir = 2'b00;
        #1 check("R10 stored BA zero", a_out, 0);

        // R1/R2/R4: preload lane 0 during isolation
        @(negedge clk);
        oe_n = 2'b11; a_in[7:0] = 8'h3C; b_in[7:0] = 8'hA5;
        pulse0(1, 1);
        a_in[7:0] = 8'h11; b_in[7:0] = 8'h22;

        // R5/R6/R7/R8: sweep all control combinations on lane 0
        for (int i = 0; i < 16; i++) begin
            logic [6:0] v;
            logic [2:0] src;
            v = VEC[i];
            src = v[2:0];
            @(negedge clk);
            oe_n[0] = v[6]; dir[0] = v[5]; sel_ab[0] = v[4]; sel_ba[0] = v[3];
            #1;
            check("R5 a_oe", a_oe[0], (src == 3 || src == 4));
            check("R5 b_oe", b_oe[0], (src == 1 || src == 2));
            check("R8 single driver", a_oe[0] & b_oe[0], 0);
            if (src == 1) check("R6 live A to B", b_out[7:0], 8'h11);
            if (src == 2) check("R6 stored to B (R1)", b_out[7:0], 8'h3C);
            if (src == 3) check("R7 live B to A", a_out[7:0], 8'h22);
            if (src == 4) check("R7 stored to A (R2)", a_out[7:0], 8'hA5);
        end

        // R3: strobe held high captures only once
        @(negedge clk);
        oe_n[0] = 1; a_in[7:0] = 8'h44; cap_ab[0] = 1;
        @(negedge clk);
        a_in[7:0] = 8'h99;
        repeat (3) @(negedge clk);
        cap_ab[0] = 0;
        repeat (2) @(negedge clk);
        oe_n[0] = 0; dir[0] = 1; sel_ab[0] = 1;
        #1 check("R3 held strobe keeps first value", b_out[7:0], 8'h44);

        // R9: A driven by the block, external A differs
        @(negedge clk);
        dir[0] = 0; sel_ba[0] = 0; b_in[7:0] = 8'h5A; a_in[7:0] = 8'hFF;
        pulse0(1, 0);
        dir[0] = 1; sel_ab[0] = 1;
        #1 check("R9 AB took driven value", b_out[7:0], 8'h5A);
        // R9: B driven by the block
        @(negedge clk);
        dir[0] = 1; sel_ab[0] = 0; a_in[7:0] = 8'h6B; b_in[7:0] = 8'h00;
        pulse0(0, 1);
        dir[0] = 0; sel_ba[0] = 1;
        #1 check("R9 BA took driven value", a_out[7:0], 8'h6B);

        // R11: lane 1 works alone, lane 0 untouched
        @(negedge clk);
        oe_n = 2'b01; dir[1] = 1; sel_ab[1] = 0; a_in[15:8] = 8'hC3;
        #1;
        check("R11 lane1 live", b_out[15:8], 8'hC3);
        check("R11 enables", {a_oe, b_oe}, 4'b0010);
        a_in[15:8] = 8'h81; cap_ab[1] = 1;
        @(negedge clk);
        cap_ab[1] = 0; sel_ab[1] = 1;
        #1 check("R11 lane1 stored", b_out[15:8], 8'h81);
        oe_n = 2'b00; dir[0] = 1; sel_ab[0] = 1;
        #1 check("R11 lane0 AB unchanged", b_out[7:0], 8'h5A);

        // R10: reset clears stored words again
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        #1 check("R10 clear after use", b_out, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule